// File: doc/BRIEF.md
# Per-Channel Gamma Lookup Table

This block applies a programmable colour gamma curve to a pixel stream shared by several display channels. Each channel owns three 256-entry tables of 8-bit values, one per colour component (red, green, blue). Every cycle a pixel carrying one 8-bit value per component and a channel number can enter the block. If gamma is enabled for that channel, each component is replaced by its table entry. If gamma is off, the pixel passes through unchanged. Both paths have one cycle of latency.

Software loads the tables through three registers. It first writes an address register, whose top bit selects auto-increment. It then streams 8-bit values through a single data register. All tables sit in one flat memory, ordered by channel and, within a channel, red then green then blue. A complete channel can therefore be loaded with one address write and 768 data writes. A third register holds one gamma-enable bit per channel.

When no channel has gamma enabled, the table memory counts as powered down. Its contents are lost at that point and come back as an identity ramp when any channel enables gamma again. For this reason, software loads the tables after it enables gamma.

Top module: `gamma_lut`

## Requirements
- R1: After reset, `pix_valid_o` is 0, `pix_o` is 0, the address register reads 0 with auto-increment clear, and the enable register reads 0.
- R2: Register select values are 0 = address, 1 = data, 2 = gamma enable, 3 = reserved. An address write stores `reg_wdata_i[AW-1:0]` as the address and bit 31 as the auto-increment flag. With the flag set, each data write stores `reg_wdata_i[7:0]` at the current address and then advances the address by one.
- R3: With auto-increment clear, a data write leaves the address unchanged, so a second write overwrites the same entry.
- R4: Auto-increment from the last entry (NUM_CH*768-1) wraps the address to 0.
- R5: The entry for channel c, component k (0 red, 1 green, 2 blue) and input value v sits at address c*768 + k*256 + v.
- R6: A valid pixel whose channel has gamma enabled appears on `pix_o` one cycle later with each component replaced by its table entry. Red is bits 23:16, green 15:8 and blue 7:0.
- R7: A valid pixel whose channel has gamma disabled appears on `pix_o` unchanged one cycle later.
- R8: `pix_valid_o` equals `pix_valid_i` delayed by one cycle. While `pix_valid_i` is low, `pix_o` holds its value.
- R9: While the enable register is all zero, data writes do not change any entry, and reading the data register returns 0.
- R10: After reset, and whenever the enable register leaves the all-zero state, every table entry equals the low 8 bits of its own address (an identity ramp).
- R11: Reads are combinational. The address register reads as bit 31 = flag and the low AW bits = address. The data register reads the entry at the current address without advancing it. The enable register reads its bits zero-extended. The reserved select reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_sel_i` |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_ch_i | input | CHW | Display channel of the input pixel |
| pix_i | input | 24 | Input pixel {red, green, blue} |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 24 | Output pixel {red, green, blue} |

## Verification
The embedded properties check several rules on every cycle:
- how the address moves on each data write: advance, hold or wrap;
- the one-cycle valid delay and the hold of `pix_o` while the input is idle;
- pass-through of pixels on channels with gamma disabled.

Only the bench scenarios can show the rest, because each depends on what software wrote earlier:
- that a load lands in the channel-major, colour-major layout;
- that lookups return the loaded values;
- that writes made while powered down are dropped;
- that the identity ramp reappears on power-up.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int LUT_ENTRIES = 256;
  localparam int COLORS      = 3;
  localparam int CH_SPAN     = COLORS * LUT_ENTRIES;
  localparam int AUTOINC_BIT = 31;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_EN   = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gamma_loader.sv
module gamma_loader
  import gamma_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int TOTAL  = NUM_CH * CH_SPAN,
  parameter int AW     = $clog2(TOTAL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [31:0]       wdata_i,
  output logic [AW-1:0]     addr_o,
  output logic              autoinc_o,
  output logic [NUM_CH-1:0] en_o,
  output logic              pwr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o
);
  logic [AW-1:0]     addr_q;
  logic              autoinc_q;
  logic [NUM_CH-1:0] en_q;
  logic              wr_addr, wr_data, wr_en, at_last;

  assign wr_addr = we_i && (sel_i == SEL_ADDR);
  assign wr_data = we_i && (sel_i == SEL_DATA);
  assign wr_en   = we_i && (sel_i == SEL_EN);
  assign at_last = int'(addr_q) >= TOTAL - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      autoinc_q <= 1'b0;
    end else if (wr_addr) begin
      addr_q    <= wdata_i[AW-1:0];
      autoinc_q <= wdata_i[AUTOINC_BIT];
    end else if (wr_data && autoinc_q) begin
      addr_q <= at_last ? '0 : addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (wr_en) en_q <= wdata_i[NUM_CH-1:0];
  end

  assign addr_o      = addr_q;
  assign autoinc_o   = autoinc_q;
  assign en_o        = en_q;
  assign pwr_o       = |en_q;
  assign mem_we_o    = wr_data && pwr_o && (int'(addr_q) < TOTAL);
  assign mem_wdata_o = wdata_i[7:0];

  // R2
  autoinc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && autoinc_q && !at_last) |=> (addr_q == $past(addr_q) + AW'(1)));
  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !autoinc_q) |=> $stable(addr_q));
  // R4
  addr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && autoinc_q && at_last) |=> (addr_q == '0));
endmodule

// File: rtl/gamma_table.sv
module gamma_table
  import gamma_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int NRD    = 4,
  parameter int TOTAL  = NUM_CH * CH_SPAN,
  parameter int AW     = $clog2(TOTAL)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pwr_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [7:0]              wdata_i,
  input  logic [NRD-1:0][AW-1:0]  rd_addr_i,
  output logic [NRD-1:0][7:0]     rd_data_o
);
  logic [7:0] mem [TOTAL];

  // Unpowered storage is held at the ramp, so power-up yields identity.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < TOTAL; j++) mem[j] <= 8'(j);
    end else if (!pwr_i) begin
      for (int j = 0; j < TOTAL; j++) mem[j] <= 8'(j);
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r] = (int'(rd_addr_i[r]) < TOTAL) ? mem[rd_addr_i[r]] : '0;
  end
endmodule

// File: rtl/gamma_pixel_path.sv
module gamma_pixel_path
  import gamma_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int TOTAL  = NUM_CH * CH_SPAN,
  parameter int AW     = $clog2(TOTAL)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [CHW-1:0]             ch_i,
  input  logic [COLORS*8-1:0]        pix_i,
  input  logic [NUM_CH-1:0]          en_i,
  output logic [COLORS-1:0][AW-1:0]  rd_addr_o,
  input  logic [COLORS-1:0][7:0]     rd_data_i,
  output logic                       valid_o,
  output logic [COLORS*8-1:0]        pix_o
);
  logic                  use_lut;
  logic [COLORS*8-1:0]   mapped;
  logic                  valid_q;
  logic [COLORS*8-1:0]   pix_q;

  assign use_lut = (int'(ch_i) < NUM_CH) && en_i[ch_i];

  // Component k (0 red) sits in the k-th byte from the top.
  for (genvar k = 0; k < COLORS; k++) begin : g_comp
    localparam int LSB = (COLORS - 1 - k) * 8;
    assign rd_addr_o[k] = AW'(int'(ch_i) * CH_SPAN + k * LUT_ENTRIES + int'(pix_i[LSB +: 8]));
    assign mapped[LSB +: 8] = rd_data_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) pix_q <= use_lut ? mapped : pix_i;
    end
  end

  assign valid_o = valid_q;
  assign pix_o   = pix_q;

  // R8
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (valid_o == $past(valid_i)));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pix_o));
  // R7
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !use_lut) |=> (pix_o == $past(pix_i)));
  // R6
  lookup_red_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && use_lut) |=> (pix_o[COLORS*8-1 -: 8] == $past(rd_data_i[0])));
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [1:0]     reg_sel_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  input  logic           pix_valid_i,
  input  logic [CHW-1:0] pix_ch_i,
  input  logic [23:0]    pix_i,
  output logic           pix_valid_o,
  output logic [23:0]    pix_o
);
  localparam int TOTAL = NUM_CH * CH_SPAN;
  localparam int AW    = $clog2(TOTAL);
  localparam int NRD   = COLORS + 1;

  logic [AW-1:0]               addr;
  logic                        autoinc;
  logic [NUM_CH-1:0]           en;
  logic                        pwr;
  logic                        mem_we;
  logic [7:0]                  mem_wdata;
  logic [COLORS-1:0][AW-1:0]   pix_rd_addr;
  logic [NRD-1:0][AW-1:0]      rd_addr;
  logic [NRD-1:0][7:0]         rd_data;
  logic [COLORS-1:0][7:0]      pix_rd_data;
  logic                        unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  gamma_loader #(.NUM_CH(NUM_CH), .TOTAL(TOTAL), .AW(AW)) u_loader (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .addr_o(addr), .autoinc_o(autoinc), .en_o(en), .pwr_o(pwr),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
  );

  assign rd_addr = {addr, pix_rd_addr};
  assign pix_rd_data = rd_data[COLORS-1:0];

  gamma_table #(.NUM_CH(NUM_CH), .NRD(NRD), .TOTAL(TOTAL), .AW(AW)) u_table (
    .clk_i, .rst_ni, .pwr_i(pwr),
    .we_i(mem_we), .waddr_i(addr), .wdata_i(mem_wdata),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  gamma_pixel_path #(.NUM_CH(NUM_CH), .CHW(CHW), .TOTAL(TOTAL), .AW(AW)) u_pix (
    .clk_i, .rst_ni,
    .valid_i(pix_valid_i), .ch_i(pix_ch_i), .pix_i(pix_i), .en_i(en),
    .rd_addr_o(pix_rd_addr), .rd_data_i(pix_rd_data),
    .valid_o(pix_valid_o), .pix_o(pix_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_i)
      SEL_ADDR: begin
        reg_rdata_o[AUTOINC_BIT] = autoinc;
        reg_rdata_o[AW-1:0]      = addr;
      end
      SEL_DATA: if (pwr) reg_rdata_o[7:0] = rd_data[NRD-1];
      SEL_EN:   reg_rdata_o[NUM_CH-1:0] = en;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: tb/gamma_lut_tb.sv
module gamma_lut_tb;
  localparam int NUM_CH = 2;
  localparam int CHW    = 1;
  localparam int TOTAL  = NUM_CH * 768;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        pix_valid_i = 1'b0;
  logic [CHW-1:0] pix_ch_i = '0;
  logic [23:0] pix_i = '0;
  logic        pix_valid_o;
  logic [23:0] pix_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk_i = ~clk_i;

  gamma_lut #(.NUM_CH(NUM_CH), .CHW(CHW)) u_dut (.*);

  // {channel, input pixel, expected pixel}; ch0 loaded, ch1 gamma off
  localparam logic [55:0] VEC [6] = '{
    {8'd0, 24'h000000, 24'hFF005A},
    {8'd0, 24'hFF80FF, 24'h0040A5},
    {8'd0, 24'h123456, 24'hED1A0C},
    {8'd1, 24'h123456, 24'h123456},
    {8'd0, 24'h01FF5A, 24'hFE7F00},
    {8'd1, 24'hABCDEF, 24'hABCDEF}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [31:0] v);
    @(negedge clk_i);
    reg_sel_i = sel;
    #1 v = reg_rdata_o;
  endtask

  task automatic px(logic [CHW-1:0] ch, logic [23:0] in, output logic [23:0] out, output logic v);
    @(negedge clk_i);
    pix_valid_i = 1'b1; pix_ch_i = ch; pix_i = in;
    @(negedge clk_i);
    out = pix_o; v = pix_valid_o;
    pix_valid_i = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    logic [23:0] o;
    logic v;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 valid_o", {31'd0, pix_valid_o}, 32'd0);
    chk("R1 pix_o", {8'd0, pix_o}, 32'd0);
    rst_ni = 1'b1;
    rd(2'd0, r); chk("R1 addr reg", r, 32'd0);
    rd(2'd2, r); chk("R1 enable reg", r, 32'd0);
    rd(2'd1, r); chk("R9 data read while off", r, 32'd0);

    // load ch0: red 255-v, green v>>1, blue v^5A (R2, R5)
    wr(2'd2, 32'd1);
    wr(2'd0, 32'h8000_0000);
    for (int i = 0; i < 256; i++) wr(2'd1, 32'(8'(255 - i)));
    for (int i = 0; i < 256; i++) wr(2'd1, 32'(8'(i >> 1)));
    for (int i = 0; i < 256; i++) wr(2'd1, 32'(8'(i) ^ 8'h5A));
    rd(2'd0, r); chk("R2 addr after 768 writes", r, 32'h8000_0300);

    // R6 R7 vector walk
    for (int i = 0; i < 6; i++) begin
      px(CHW'(VEC[i][55:48]), VEC[i][47:24], o, v);
      chk(VEC[i][48] ? "R7 bypass" : "R6 lookup", {8'd0, o}, {8'd0, VEC[i][23:0]});
      chk("R8 valid_o", {31'd0, v}, 32'd1);
    end

    // R8 hold while idle
    @(negedge clk_i); pix_i = 24'h5555AA; pix_ch_i = '0;
    @(negedge clk_i);
    chk("R8 hold pix_o", {8'd0, pix_o}, 32'h00ABCDEF);
    chk("R8 valid low", {31'd0, pix_valid_o}, 32'd0);

    // R3 R5: ch1 edits without auto-increment
    wr(2'd2, 32'd3);
    wr(2'd0, 32'h0000_0310);
    wr(2'd1, 32'h99);
    wr(2'd1, 32'h98);
    rd(2'd0, r); chk("R3 addr unchanged", r, 32'h0000_0310);
    rd(2'd1, r); chk("R3 overwrite same entry", r, 32'h98);
    wr(2'd0, 32'h0000_0420);
    wr(2'd1, 32'h77);
    px(1'b1, 24'h102030, o, v);
    chk("R5 ch1 layout", {8'd0, o}, 32'h00987730);
    px(1'b1, 24'h112131, o, v);
    chk("R5 ch1 neighbours identity", {8'd0, o}, 32'h00112131);

    // R4 wrap
    wr(2'd0, 32'h8000_0000 | 32'(TOTAL - 1));
    wr(2'd1, 32'h33);
    rd(2'd0, r); chk("R4 wrap to 0", r, 32'h8000_0000);
    rd(2'd1, r); chk("R11 data read at 0", r, 32'hFF);
    rd(2'd0, r); chk("R11 read does not advance", r, 32'h8000_0000);
    px(1'b1, 24'h0000FF, o, v);
    chk("R4 last entry written", {8'd0, o}, 32'h00000033);

    // R11 reserved select
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, r); chk("R11 reserved reads 0", r, 32'd0);
    rd(2'd2, r); chk("R11 reserved write ignored", r, 32'd3);

    // R9 R10 power down and back up
    wr(2'd0, 32'd5);
    wr(2'd2, 32'd0);
    wr(2'd1, 32'hEE);
    rd(2'd1, r); chk("R9 data read while off", r, 32'd0);
    px(1'b0, 24'h050505, o, v);
    chk("R7 all off bypass", {8'd0, o}, 32'h00050505);
    wr(2'd2, 32'd1);
    rd(2'd1, r); chk("R10 identity after power-up", r, 32'h05);
    px(1'b0, 24'h0506FE, o, v);
    chk("R10 lookup identity", {8'd0, o}, 32'h000506FE);

    done = 1;
    summary();
  end
endmodule